// File: doc/BRIEF.md
# Receiver Clock-Source Supervisor

This block decides which clock drives the receive side of a digital audio interface receiver. One source is the clock recovered by the PLL. The other is a local crystal-oscillator clock. Both clocks are seen as clock-enable samples in the system clock domain: `vco_en` for the PLL clock and `osc_en` for the oscillator. The block passes one of them to `ck_en`. The oscillator enable is also always available on its own output, so the oscillator clock can be used whatever the PLL is doing.

A PLL lock indication alone does not mark the receiver as healthy. After the lock indication rises, the block counts block-start (preamble-B) strobes from the frame decoder. Only when a selectable number of them has arrived does the receiver count as qualified. The error flag then clears, and the PLL clock becomes the wanted source. When lock is lost, the block waits for the oscillator to report that it is running. It then counts a selectable number of microsecond ticks before the oscillator becomes the wanted source. The actual change of source happens only in a cycle where both enables are low, so no output pulse is cut short or doubled. A transition flag is high while the wanted source and the current source differ.

Four status events are latched into a sticky register, each with its own mask bit. A read strobe clears the register. The interrupt output is high while any unmasked latched bit is set.

Top module: `rx_clk_supervisor`

## Requirements
- R1: After reset, `src_pll` is 0 (oscillator selected), `xfer` is 0, `irq_stat` is 0, `irq` is 0 and `rerr` is 1.
- R2: While `pll_lock` is high, each `pblk_stb` pulse is counted. The count needed is 3, 6, 12 or 24 for `lock_wait_sel` = 0, 1, 2 or 3. The receiver is qualified from the cycle after the clock edge that records the last needed strobe.
- R3: Whenever `pll_lock` is low, the strobe count returns to zero, and qualification must be earned again from the start.
- R4: `rerr` is high when the receiver is not qualified or when `data_err` is high, and low otherwise.
- R5: An `osc_start` pulse is accepted only while the receiver is not qualified. Microsecond ticks are counted from the cycle after acceptance. Once the count reaches 0, 50, 100 or 200 for `unlock_wait_sel` = 0, 1, 2 or 3, the oscillator becomes the wanted source. Qualification cancels the wait and makes the PLL the wanted source.
- R6: `src_pll` takes the wanted source only at a clock edge where `vco_en` and `osc_en` are both low. It never changes at any other edge.
- R7: `ck_en` equals `vco_en` while `src_pll` is 1 and `osc_en` while it is 0.
- R8: `xfer` is high exactly while the wanted source differs from `src_pll`.
- R9: `osc_ck_en` always follows `osc_en`, whatever the lock and selection state.
- R10: `irq_stat` is sticky. Bit 0 sets when qualification is gained and bit 1 when it is lost, each one edge after the `rerr` change that shows it. Bit 2 sets at the edge where `src_pll` changes. Bit 3 sets at the edge after a rising edge of `data_err`. An `irq_rd` pulse clears all bits, but an event at the same edge still sets its bit.
- R11: `irq` is high exactly while some bit set in `irq_stat` is also set in `irq_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock | input | 1 | PLL lock indication |
| pblk_stb | input | 1 | One-cycle block-start preamble strobe |
| osc_start | input | 1 | One-cycle oscillator-running event |
| us_tick | input | 1 | One-cycle microsecond tick |
| vco_en | input | 1 | Enable samples of the recovered PLL clock |
| osc_en | input | 1 | Enable samples of the oscillator clock |
| data_err | input | 1 | Data error from the frame decoder |
| lock_wait_sel | input | 2 | Strobe count selector for qualification |
| unlock_wait_sel | input | 2 | Microsecond wait selector after lock loss |
| irq_mask | input | 4 | Per-bit interrupt mask, 1 = enabled |
| irq_rd | input | 1 | Status read strobe, clears `irq_stat` |
| ck_en | output | 1 | Selected clock enable |
| osc_ck_en | output | 1 | Oscillator clock enable, always present |
| src_pll | output | 1 | 1 = PLL clock selected, 0 = oscillator |
| xfer | output | 1 | Source switch pending |
| rerr | output | 1 | Combined clock and data error flag |
| irq | output | 1 | Interrupt request |
| irq_stat | output | 4 | Latched status events |

## Verification
The main collision is a status read landing at the same edge as a new event. This can be a qualification change, a source switch or a data-error rise. The expected result is that the bit for the new event survives the clear. Long random runs drive `irq_rd`, `data_err`, lock changes and both enable patterns at the same time, so these overlaps occur many times. Each cycle, the latched word and `irq` are compared against a reference model built from the requirements. A second overlap happens when qualification returns while the unlock wait is still running. The expected result is that the wait is cancelled without any switch to the oscillator, and the same per-cycle comparison of `xfer` and `src_pll` covers it.

// File: rtl/rx_clk_supervisor.sv
module rx_clk_supervisor #(
  parameter int US_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pll_lock,
  input  logic       pblk_stb,
  input  logic       osc_start,
  input  logic       us_tick,
  input  logic       vco_en,
  input  logic       osc_en,
  input  logic       data_err,
  input  logic [1:0] lock_wait_sel,
  input  logic [1:0] unlock_wait_sel,
  input  logic [3:0] irq_mask,
  input  logic       irq_rd,
  output logic       ck_en,
  output logic       osc_ck_en,
  output logic       src_pll,
  output logic       xfer,
  output logic       rerr,
  output logic       irq,
  output logic [3:0] irq_stat
);

  logic [4:0]      pb_cnt, pb_need;
  logic [US_W-1:0] us_cnt, us_need;
  logic            lk, lk_q, derr_q, tgt_pll, osc_run, osc_go, sw_ok;
  logic [3:0]      ev;

  assign pb_need = 5'd3 << lock_wait_sel;

  always_comb begin
    case (unlock_wait_sel)
      2'd0:    us_need = US_W'(0);
      2'd1:    us_need = US_W'(50);
      2'd2:    us_need = US_W'(100);
      default: us_need = US_W'(200);
    endcase
  end

  assign lk     = pll_lock && (pb_cnt >= pb_need);
  assign osc_go = osc_run && (us_cnt >= us_need);
  assign sw_ok  = !vco_en && !osc_en;

  assign ck_en     = src_pll ? vco_en : osc_en;
  assign osc_ck_en = osc_en;
  assign xfer      = src_pll != tgt_pll;
  assign rerr      = !lk || data_err;
  assign irq       = |(irq_stat & irq_mask);

  assign ev = {data_err && !derr_q, sw_ok && xfer, !lk && lk_q, lk && !lk_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_cnt   <= '0;
      us_cnt   <= '0;
      lk_q     <= 1'b0;
      derr_q   <= 1'b0;
      osc_run  <= 1'b0;
      tgt_pll  <= 1'b0;
      src_pll  <= 1'b0;
      irq_stat <= '0;
    end else begin
      if (!pll_lock)
        pb_cnt <= '0;
      else if (pblk_stb && pb_cnt < pb_need)
        pb_cnt <= pb_cnt + 5'd1;

      if (lk)
        osc_run <= 1'b0;
      else if (osc_start)
        osc_run <= 1'b1;

      if (!osc_run)
        us_cnt <= '0;
      else if (us_tick && us_cnt != '1)
        us_cnt <= us_cnt + 1'b1;

      if (lk)
        tgt_pll <= 1'b1;
      else if (osc_go)
        tgt_pll <= 1'b0;

      if (sw_ok)
        src_pll <= tgt_pll;

      lk_q     <= lk;
      derr_q   <= data_err;
      irq_stat <= (irq_rd ? 4'd0 : irq_stat) | ev;
    end
  end

endmodule

module rx_clk_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_lock,
  input logic       vco_en,
  input logic       osc_en,
  input logic       src_pll,
  input logic       xfer,
  input logic       rerr,
  input logic       tgt_pll,
  input logic       osc_run,
  input logic [4:0] pb_cnt
);

  a_r4_err_without_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock |-> rerr);

  a_r3_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock |=> (pb_cnt == 5'd0));

  a_r6_switch_at_low: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pll != $past(src_pll)) |-> (!$past(vco_en) && !$past(osc_en)));

  a_r8_hold_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && (vco_en || osc_en)) |=> $stable(src_pll));

  a_r5_osc_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_pll) |-> $past(osc_run));

endmodule

bind rx_clk_supervisor rx_clk_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .vco_en(vco_en),
  .osc_en(osc_en), .src_pll(src_pll), .xfer(xfer), .rerr(rerr),
  .tgt_pll(tgt_pll), .osc_run(osc_run), .pb_cnt(pb_cnt)
);

// File: tb/sim_rx_clk_supervisor.sv
module sim_rx_clk_supervisor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pll_lock = 0, pblk_stb = 0, osc_start = 0, us_tick = 0, vco_en = 0, osc_en = 0, data_err = 0, irq_rd = 0;
  logic [1:0] lock_wait_sel = 0, unlock_wait_sel = 0;
  logic [3:0] irq_mask = 0;
  logic ck_en, osc_ck_en, src_pll, xfer, rerr, irq;
  logic [3:0] irq_stat;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state derived from the requirements
  int m_pb = 0, m_us = 0;
  bit m_lkq = 0, m_dq = 0, m_tgt = 0, m_run = 0, m_src = 0;
  logic [3:0] m_stat = 0;

  always #5 clk = ~clk;

  rx_clk_supervisor u0 (.*);

  function automatic int need_pb(input logic [1:0] s);
    return 3 << s;
  endfunction

  function automatic int need_us(input logic [1:0] s);
    case (s)
      2'd0: return 0;
      2'd1: return 50;
      2'd2: return 100;
      default: return 200;
    endcase
  endfunction

  function automatic bit m_lk();
    return pll_lock && (m_pb >= need_pb(lock_wait_sel));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R7 ck_en", ck_en, m_src ? vco_en : osc_en);
    check("R9 osc_ck_en", osc_ck_en, osc_en);
    check("R6 src_pll", src_pll, m_src);
    check("R8 R5 xfer", xfer, m_src != m_tgt);
    check("R2 R3 R4 rerr", rerr, !m_lk() || data_err);
    check("R10 irq_stat", irq_stat, m_stat);
    check("R11 irq", irq, |(m_stat & irq_mask));
  endtask

  // inputs are already applied; check, then advance the model across the edge
  task automatic step();
    bit lk, sw, go;
    logic [3:0] ev;
    #1 compare_all();
    lk = m_lk();
    sw = !vco_en && !osc_en;
    go = m_run && (m_us >= need_us(unlock_wait_sel));
    ev = {data_err && !m_dq, sw && (m_src != m_tgt), !lk && m_lkq, lk && !m_lkq};
    @(posedge clk);
    if (!pll_lock) m_pb = 0;
    else if (pblk_stb && m_pb < need_pb(lock_wait_sel)) m_pb++;
    if (!m_run) m_us = 0;
    else if (us_tick && m_us < 255) m_us++;
    if (lk) m_run = 0; else if (osc_start) m_run = 1;
    if (sw) m_src = m_tgt;
    if (lk) m_tgt = 1; else if (go) m_tgt = 0;
    m_lkq = lk;
    m_dq = data_err;
    m_stat = (irq_rd ? 4'd0 : m_stat) | ev;
    #1;
  endtask

  task automatic idle_in();
    pblk_stb = 0; osc_start = 0; us_tick = 0; irq_rd = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 src_pll", src_pll, 0);
    check("R1 xfer", xfer, 0);
    check("R1 irq_stat", irq_stat, 0);
    check("R1 irq", irq, 0);
    check("R1 rerr", rerr, 1);
    rst_n = 1;
    @(posedge clk); #1;
    irq_mask = 4'hF;

    // R2: each qualification count, strobe every cycle
    for (int s = 0; s < 4; s++) begin
      lock_wait_sel = 2'(s);
      pll_lock = 0; vco_en = 0; osc_en = 0; idle_in();
      step(); step();
      pll_lock = 1; pblk_stb = 1;
      for (int k = 0; k < need_pb(2'(s)); k++) begin
        if (k == need_pb(2'(s)) - 1) begin #1 check("R2 rerr before last", rerr, 1); #0; end
        step();
      end
      pblk_stb = 0;
      #1 check("R2 rerr after count", rerr, 0);
      step(); step();
      check("R6 R2 switched to pll", src_pll, 1);
      check("R10 lock gain bit", irq_stat[0], 1);
      irq_rd = 1; step(); irq_rd = 0;
    end

    // R3: lock drop midway restarts the count
    lock_wait_sel = 2'd1;
    pll_lock = 0; step();
    pll_lock = 1; pblk_stb = 1;
    repeat (4) step();
    pll_lock = 0; step();
    pll_lock = 1;
    repeat (5) step();
    pblk_stb = 0;
    #1 check("R3 still unqualified after restart", rerr, 1);
    pblk_stb = 1; step(); pblk_stb = 0;
    #1 check("R3 qualified after full recount", rerr, 0);
    step(); step();

    // R5: unlock wait length, enables held high so no switch happens
    for (int s = 0; s < 4; s++) begin
      unlock_wait_sel = 2'(s);
      lock_wait_sel = 2'd0;
      vco_en = 0; osc_en = 0; pll_lock = 1; pblk_stb = 1;
      repeat (4) step();
      pblk_stb = 0; step();
      pll_lock = 0; vco_en = 1; osc_en = 1; step();
      osc_start = 1; us_tick = 1;
      n = 0;
      step(); osc_start = 0;
      while (!xfer && n < 400) begin n++; step(); end
      check("R5 wait steps", n + 1, need_us(2'(s)) + 2);
      us_tick = 0;
      vco_en = 0; osc_en = 0; step(); step();
      check("R6 switched to osc", src_pll, 0);
      check("R9 osc still visible", osc_ck_en, 0);
    end

    // random mixed phase, compared every cycle
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 40) == 0) pll_lock = ~pll_lock;
      if ($urandom_range(0, 200) == 0) lock_wait_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 200) == 0) unlock_wait_sel = 2'($urandom_range(0, 1));
      if ($urandom_range(0, 100) == 0) irq_mask = 4'($urandom_range(0, 15));
      pblk_stb = ($urandom_range(0, 1) == 0);
      osc_start = ($urandom_range(0, 15) == 0);
      us_tick = ($urandom_range(0, 1) == 0);
      vco_en = ($urandom_range(0, 2) == 0);
      osc_en = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 20) == 0) data_err = ~data_err;
      irq_rd = ($urandom_range(0, 7) == 0);
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule